// File: doc/BRIEF.md
# Conversion Trigger Scheduler with Programmable Delay

This block sits in front of an analog-to-digital converter and decides when each of its sample slots asks for a conversion. Every slot watches one hardware event source chosen by a 4-bit code. It can also be started directly by a software start bit. After an accepted event the slot waits a programmable number of prescaled delay ticks, then raises its pending flag and holds it until the converter grants it.

The converter sees a single request: the lowest-numbered pending slot together with a valid flag. It answers with a one-cycle grant, which retires that slot. If an event arrives while a slot still has an earlier event waiting or delaying, the new event is dropped and a sticky overrun flag is raised. The overrun flag is cleared by writing 1 to it. A summary output shows whether any slot has overrun.

Top module: `conv_trig_sched`

## Requirements
- R1: After reset, `pending`, `overrun`, `any_overrun` and `req_valid` are 0.
- R2: The 4-bit source code of a slot selects its hardware event as follows. Code 0 selects nothing. Code 1 selects the external pin. Codes 2 and 3 select `eoc_pulse[0]` and `eoc_pulse[1]`. Codes 4 to 7 select `tmr_ovf[0..3]`. Codes 8 to 15 select `pwm_evt[0..7]`. Any input other than the selected one has no effect on the slot.
- R3: With code 1, a rise of `ext_pin` is an event when the slot's rise enable is 1, and a fall is an event when its fall enable is 1. Both enables together accept both edges.
- R4: A 1 on `sw_start[i]` in a cycle is an event for slot i whatever its source code is. A 0 does nothing.
- R5: Let D be the slot's delay count and let the divide code be 0, 1, 2 or 3, giving a divisor of 1, 2, 4 or 16. An accepted event sampled at clock edge t sets `pending` at edge t + D×divisor. When D = 0, `pending` reads 1 in the cycle that follows the event.
- R6: `req_valid` is 1 exactly when some `pending` bit is 1, and `req_slot` is then the lowest-numbered pending slot.
- R7: A `grant` sampled while `req_valid` is 1 clears the pending bit of `req_slot` at that edge.
- R8: A pending bit stays at 1 until it is granted.
- R9: An event for a slot that is already pending or still delaying sets that slot's `overrun` bit and is otherwise dropped, so the timing of the earlier event does not change. The overrun bit stays at 1 until a 1 on `ovr_clr` clears it. When a new overrun and a clear arrive in the same cycle, the overrun wins.
- R10: `any_overrun` is 1 exactly when some `overrun` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External trigger pin level |
| eoc_pulse | input | 2 | End-of-conversion event pulses |
| tmr_ovf | input | 4 | Timer overflow pulses |
| pwm_evt | input | 8 | PWM trigger event pulses |
| cfg_src | input | NSLOT*4 | Source code per slot |
| cfg_dly | input | NSLOT*DLY_W | Delay count per slot |
| cfg_div | input | NSLOT*2 | Delay clock divide code per slot |
| cfg_ext_rise | input | NSLOT | Accept a rise of the external pin, per slot |
| cfg_ext_fall | input | NSLOT | Accept a fall of the external pin, per slot |
| sw_start | input | NSLOT | Software start, one bit per slot |
| ovr_clr | input | NSLOT | Write 1 to clear an overrun bit |
| grant | input | 1 | Converter accepts the current request |
| pending | output | NSLOT | Start of conversion waiting, per slot |
| overrun | output | NSLOT | Sticky overrun flag, per slot |
| any_overrun | output | 1 | At least one overrun bit is set |
| req_valid | output | 1 | Some slot is pending |
| req_slot | output | log2(NSLOT) | Lowest pending slot index |

## Verification
A pending bit is due D×divisor edges after the edge that sampled its event. When D is zero it appears right after that edge. Overrun setting and clearing, grant retirement and the edge detection on the external pin all take effect at the edge that samples the stimulus. `req_valid`, `req_slot` and `any_overrun` follow the flags within that same cycle. The bench drives every input on the falling edge and steps a behavioural model once per rising edge. It compares all outputs at the next falling edge, so each expected value is checked in exactly the cycle it is due. For delays it counts cycles explicitly and checks the flag one cycle early as well as on time.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int SRC_W = 4;
  localparam int DIV_W = 2;
  localparam int PRE_W = 4;
  localparam int N_EOC = 2;
  localparam int N_TMR = 4;
  localparam int N_PWM = 8;

  // source code map; the positions are decoded by the trigger mux
  localparam int SRC_EXT  = 1;
  localparam int SRC_EOC0 = 2;
  localparam int SRC_TMR0 = 4;
  localparam int SRC_PWM0 = 8;

  typedef enum logic [DIV_W-1:0] {
    DIV_1  = 2'd0,
    DIV_2  = 2'd1,
    DIV_4  = 2'd2,
    DIV_16 = 2'd3
  } dly_div_e;

  // terminal value of the delay prescaler for each divide code
  function automatic logic [PRE_W-1:0] div_limit(input dly_div_e d);
    case (d)
      DIV_1:   return PRE_W'(0);
      DIV_2:   return PRE_W'(1);
      DIV_4:   return PRE_W'(3);
      default: return PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/cs_trig_mux.sv
module cs_trig_mux
  import conv_sched_pkg::*;
(
  input  logic [SRC_W-1:0] sel,
  input  logic             ext_rise,
  input  logic             ext_fall,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic [N_EOC-1:0] eoc,
  input  logic [N_TMR-1:0] tmr,
  input  logic [N_PWM-1:0] pwm,
  input  logic             sw_start,
  output logic             evt
);
  localparam int NCODE = 2 ** SRC_W;

  logic [NCODE-1:0] hw_vec;

  always_comb begin
    hw_vec                      = '0;
    hw_vec[SRC_EXT]             = (ext_rise & en_rise) | (ext_fall & en_fall);
    hw_vec[SRC_EOC0 +: N_EOC]   = eoc;
    hw_vec[SRC_TMR0 +: N_TMR]   = tmr;
    hw_vec[SRC_PWM0 +: N_PWM]   = pwm;
    evt                         = sw_start | hw_vec[sel];
  end
endmodule

// File: rtl/cs_slot_timer.sv
module cs_slot_timer
  import conv_sched_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [DLY_W-1:0] dly,
  input  dly_div_e         div,
  input  logic             grant_me,
  input  logic             ovr_clr,
  output logic             pending,
  output logic             overrun
);
  logic             busy;
  logic [DLY_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic             outstanding;
  logic             tick;

  assign outstanding = pending | busy;
  assign tick        = (pre == div_limit(div));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      pre     <= '0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (grant_me) pending <= 1'b0;

      if (evt && !outstanding) begin
        if (dly == '0) begin
          pending <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= dly;
          pre  <= '0;
        end
      end else if (busy) begin
        if (tick) begin
          pre <= '0;
          if (cnt == DLY_W'(1)) begin
            busy    <= 1'b0;
            pending <= 1'b1;
          end else begin
            cnt <= cnt - DLY_W'(1);
          end
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end

      if (evt && outstanding) overrun <= 1'b1;
      else if (ovr_clr)       overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     pend,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    valid = |pend;
  end
endmodule

// File: rtl/conv_trig_sched.sv
module conv_trig_sched
  import conv_sched_pkg::*;
#(
  parameter  int NSLOT = 16,
  parameter  int DLY_W = 8,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ext_pin,
  input  logic [N_EOC-1:0]       eoc_pulse,
  input  logic [N_TMR-1:0]       tmr_ovf,
  input  logic [N_PWM-1:0]       pwm_evt,
  input  logic [NSLOT*SRC_W-1:0] cfg_src,
  input  logic [NSLOT*DLY_W-1:0] cfg_dly,
  input  logic [NSLOT*DIV_W-1:0] cfg_div,
  input  logic [NSLOT-1:0]       cfg_ext_rise,
  input  logic [NSLOT-1:0]       cfg_ext_fall,
  input  logic [NSLOT-1:0]       sw_start,
  input  logic [NSLOT-1:0]       ovr_clr,
  input  logic                   grant,
  output logic [NSLOT-1:0]       pending,
  output logic [NSLOT-1:0]       overrun,
  output logic                   any_overrun,
  output logic                   req_valid,
  output logic [IDX_W-1:0]       req_slot
);
  logic             ext_q;
  logic             ext_rise;
  logic             ext_fall;
  logic [NSLOT-1:0] slot_evt;
  logic [NSLOT-1:0] grant_vec;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_pin;
  end

  assign ext_rise = ext_pin & ~ext_q;
  assign ext_fall = ~ext_pin & ext_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign grant_vec[g] = grant & req_valid & (req_slot == IDX_W'(g));

    cs_trig_mux u_mux (
      .sel      (cfg_src[g*SRC_W +: SRC_W]),
      .ext_rise (ext_rise),
      .ext_fall (ext_fall),
      .en_rise  (cfg_ext_rise[g]),
      .en_fall  (cfg_ext_fall[g]),
      .eoc      (eoc_pulse),
      .tmr      (tmr_ovf),
      .pwm      (pwm_evt),
      .sw_start (sw_start[g]),
      .evt      (slot_evt[g])
    );

    cs_slot_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .evt      (slot_evt[g]),
      .dly      (cfg_dly[g*DLY_W +: DLY_W]),
      .div      (dly_div_e'(cfg_div[g*DIV_W +: DIV_W])),
      .grant_me (grant_vec[g]),
      .ovr_clr  (ovr_clr[g]),
      .pending  (pending[g]),
      .overrun  (overrun[g])
    );
  end

  cs_prio_pick #(.N(NSLOT), .IDX_W(IDX_W)) u_pick (
    .pend  (pending),
    .valid (req_valid),
    .idx   (req_slot)
  );

  assign any_overrun = |overrun;
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int NSLOT = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             grant,
  input logic [NSLOT-1:0] ovr_clr,
  input logic [NSLOT-1:0] pending,
  input logic [NSLOT-1:0] overrun,
  input logic             req_valid,
  input logic [IDX_W-1:0] req_slot
);
  // R6: the request names a pending slot with no lower pending slot
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (pending[req_slot] &&
                   ((pending & ((NSLOT'(1) << req_slot) - NSLOT'(1))) == '0)));

  // R7: a granted slot is no longer pending after the edge
  a_r7_grant_clears: assert property (@(posedge clk) disable iff (rst)
    (grant && req_valid) |=> !pending[$past(req_slot)]);

  // R8: without a grant no pending bit drops
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (rst)
    !(grant && req_valid) |=> (($past(pending) & ~pending) == '0));

  // R9: an overrun bit only drops after a clear request for it
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    ((($past(overrun) & ~overrun) & ~$past(ovr_clr)) == '0));
endmodule

bind conv_trig_sched conv_sched_chk #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .grant     (grant),
  .ovr_clr   (ovr_clr),
  .pending   (pending),
  .overrun   (overrun),
  .req_valid (req_valid),
  .req_slot  (req_slot)
);

// File: tb/conv_trig_sched_tb.sv
module conv_trig_sched_tb;
  localparam int NS = 16;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ext_pin = 1'b0;
  logic [1:0]      eoc_pulse = '0;
  logic [3:0]      tmr_ovf = '0;
  logic [7:0]      pwm_evt = '0;
  logic [NS*4-1:0] cfg_src = '0;
  logic [NS*DW-1:0] cfg_dly = '0;
  logic [NS*2-1:0] cfg_div = '0;
  logic [NS-1:0]   cfg_ext_rise = '0;
  logic [NS-1:0]   cfg_ext_fall = '0;
  logic [NS-1:0]   sw_start = '0;
  logic [NS-1:0]   ovr_clr = '0;
  logic            grant = 1'b0;
  logic [NS-1:0]   d_pend;
  logic [NS-1:0]   d_ovr;
  logic            d_any;
  logic            d_rv;
  logic [3:0]      d_slot;

  int n_chk = 0;
  int n_err = 0;

  // behavioural model state
  bit m_pend [NS];
  bit m_ovr  [NS];
  int m_rem  [NS];
  bit ext_prev = 1'b0;

  always #10 clk = ~clk;

  conv_trig_sched #(.NSLOT(NS), .DLY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .eoc_pulse(eoc_pulse),
    .tmr_ovf(tmr_ovf), .pwm_evt(pwm_evt), .cfg_src(cfg_src),
    .cfg_dly(cfg_dly), .cfg_div(cfg_div), .cfg_ext_rise(cfg_ext_rise),
    .cfg_ext_fall(cfg_ext_fall), .sw_start(sw_start), .ovr_clr(ovr_clr),
    .grant(grant), .pending(d_pend), .overrun(d_ovr), .any_overrun(d_any),
    .req_valid(d_rv), .req_slot(d_slot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int divisor(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 16;
    endcase
  endfunction

  // R2/R3 source decode from the requirement table
  function automatic bit hw_hit(input int i);
    int code = int'(cfg_src[i*4 +: 4]);
    bit rise = ext_pin && !ext_prev;
    bit fall = !ext_pin && ext_prev;
    if (code == 0) return 1'b0;
    if (code == 1) return (rise && cfg_ext_rise[i]) || (fall && cfg_ext_fall[i]);
    if (code < 4)  return eoc_pulse[code-2];
    if (code < 8)  return tmr_ovf[code-4];
    return pwm_evt[code-8];
  endfunction

  // one clock: advance the model, let the edge pass, compare, drop pulses
  task automatic cycle();
    bit n_pend [NS];
    bit n_ovr  [NS];
    int n_rem  [NS];
    int gsel = -1;
    logic [NS-1:0] ep = '0;
    logic [NS-1:0] eo = '0;
    int lo = 0;
    if (grant) begin
      for (int i = NS - 1; i >= 0; i--) if (m_pend[i]) gsel = i;
    end
    for (int i = 0; i < NS; i++) begin
      bit ev   = sw_start[i] || hw_hit(i);
      bit outs = m_pend[i] || (m_rem[i] > 0);
      int d    = int'(cfg_dly[i*DW +: DW]);
      n_pend[i] = m_pend[i];
      n_rem[i]  = m_rem[i];
      n_ovr[i]  = m_ovr[i];
      if (gsel == i) n_pend[i] = 1'b0;
      if (ev && !outs) begin
        if (d == 0) n_pend[i] = 1'b1;
        else n_rem[i] = d * divisor(int'(cfg_div[i*2 +: 2]));
      end else if (m_rem[i] > 0) begin
        n_rem[i] = m_rem[i] - 1;
        if (n_rem[i] == 0) n_pend[i] = 1'b1;
      end
      if (ev && outs) n_ovr[i] = 1'b1;
      else if (ovr_clr[i]) n_ovr[i] = 1'b0;
    end
    @(posedge clk);
    ext_prev = ext_pin;
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      m_pend[i] = n_pend[i];
      m_ovr[i]  = n_ovr[i];
      m_rem[i]  = n_rem[i];
      ep[i] = m_pend[i];
      eo[i] = m_ovr[i];
    end
    for (int i = NS - 1; i >= 0; i--) if (ep[i]) lo = i;
    chk("R8 pending", 32'(d_pend), 32'(ep));
    chk("R9 overrun", 32'(d_ovr), 32'(eo));
    chk("R10 summary", 32'(d_any), 32'(eo != '0));
    chk("R6 valid", 32'(d_rv), 32'(ep != '0));
    if (ep != '0) chk("R6 slot", 32'(d_slot), 32'(lo));
    sw_start  = '0;
    eoc_pulse = '0;
    tmr_ovf   = '0;
    pwm_evt   = '0;
    ovr_clr   = '0;
    grant     = 1'b0;
  endtask

  task automatic grant_one();
    grant = 1'b1;
    cycle();
  endtask

  task automatic delay_test(input int s, input int d, input int dv);
    int n = d * divisor(dv);
    cfg_dly[s*DW +: DW] = DW'(d);
    cfg_div[s*2 +: 2]   = 2'(dv);
    sw_start[s] = 1'b1;
    cycle();
    repeat (n - 1) cycle();
    chk("R5 early", 32'(d_pend[s]), 32'd0);
    cycle();
    chk("R5 due", 32'(d_pend[s]), 32'd1);
    grant_one();
    cfg_dly[s*DW +: DW] = '0;
    cfg_div[s*2 +: 2]   = '0;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NS; i++) begin
      m_pend[i] = 1'b0;
      m_ovr[i]  = 1'b0;
      m_rem[i]  = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pending", 32'(d_pend), 32'd0);
    chk("R1 overrun", 32'(d_ovr), 32'd0);
    chk("R1 summary", 32'(d_any), 32'd0);
    chk("R1 valid", 32'(d_rv), 32'd0);

    // R4 software start, R8 hold, R7 grant
    sw_start[3] = 1'b1;
    cycle();
    chk("R4 start", 32'(d_pend), 32'h0008);
    cycle();
    chk("R8 hold", 32'(d_pend), 32'h0008);
    grant_one();
    chk("R7 cleared", 32'(d_pend), 32'h0);

    // R2 code 0 ignores every source
    cfg_ext_rise[0] = 1'b1;
    ext_pin = 1'b1; eoc_pulse = '1; tmr_ovf = '1; pwm_evt = '1;
    cycle();
    chk("R2 code0", 32'(d_pend), 32'h0);
    ext_pin = 1'b0;
    cycle();
    cfg_ext_rise[0] = 1'b0;

    // R2 each event code on slot 0
    for (int c = 2; c < 16; c++) begin
      cfg_src[3:0] = 4'(c);
      if (c < 4) eoc_pulse[c-2] = 1'b1;
      else if (c < 8) tmr_ovf[c-4] = 1'b1;
      else pwm_evt[c-8] = 1'b1;
      cycle();
      chk("R2 select", 32'(d_pend), 32'h0001);
      grant_one();
    end
    // R2 unselected inputs have no effect
    cfg_src[3:0] = 4'd5;
    tmr_ovf = 4'b1101; pwm_evt = '1; eoc_pulse = '1;
    cycle();
    chk("R2 other", 32'(d_pend), 32'h0);
    cfg_src[3:0] = 4'd0;

    // R3 external pin edges on slot 1
    cfg_src[7:4] = 4'd1;
    cfg_ext_rise[1] = 1'b1;
    ext_pin = 1'b1; cycle();
    chk("R3 rise", 32'(d_pend), 32'h0002);
    grant_one();
    ext_pin = 1'b0; cycle();
    chk("R3 fall off", 32'(d_pend), 32'h0);
    cfg_ext_rise[1] = 1'b0; cfg_ext_fall[1] = 1'b1;
    ext_pin = 1'b1; cycle();
    chk("R3 rise off", 32'(d_pend), 32'h0);
    ext_pin = 1'b0; cycle();
    chk("R3 fall", 32'(d_pend), 32'h0002);
    grant_one();
    cfg_ext_rise[1] = 1'b1;
    ext_pin = 1'b1; cycle();
    chk("R3 both rise", 32'(d_pend), 32'h0002);
    grant_one();
    ext_pin = 1'b0; cycle();
    chk("R3 both fall", 32'(d_pend), 32'h0002);
    grant_one();
    cfg_src[7:4] = 4'd0;

    // R5 delay and prescaler
    delay_test(2, 3, 2);
    delay_test(2, 1, 3);
    delay_test(10, 2, 1);
    delay_test(15, 5, 0);

    // R6 priority ordering
    sw_start[4] = 1'b1; sw_start[9] = 1'b1; sw_start[12] = 1'b1;
    cycle();
    chk("R6 first", 32'(d_slot), 32'd4);
    grant_one();
    chk("R6 second", 32'(d_slot), 32'd9);
    grant_one();
    chk("R6 third", 32'(d_slot), 32'd12);
    grant_one();
    chk("R6 empty", 32'(d_rv), 32'd0);

    // R9 overrun, R10 summary
    sw_start[7] = 1'b1; cycle();
    sw_start[7] = 1'b1; cycle();
    chk("R9 set", 32'(d_ovr), 32'h0080);
    chk("R10 set", 32'(d_any), 32'd1);
    chk("R9 kept pending", 32'(d_pend), 32'h0080);
    cycle();
    chk("R9 sticky", 32'(d_ovr), 32'h0080);
    sw_start[7] = 1'b1; ovr_clr[7] = 1'b1; cycle();
    chk("R9 set wins", 32'(d_ovr), 32'h0080);
    ovr_clr[7] = 1'b1; cycle();
    chk("R9 cleared", 32'(d_ovr), 32'h0);
    chk("R10 cleared", 32'(d_any), 32'd0);
    grant_one();
    // R9 event during delay keeps original timing
    cfg_dly[6*DW +: DW] = DW'(2);
    sw_start[6] = 1'b1; cycle();
    sw_start[6] = 1'b1; cycle();
    chk("R9 delay ovr", 32'(d_ovr), 32'h0040);
    chk("R9 delay early", 32'(d_pend), 32'h0);
    cycle();
    chk("R9 delay due", 32'(d_pend), 32'h0040);
    ovr_clr[6] = 1'b1; grant_one();
    cfg_dly[6*DW +: DW] = '0;

    // constrained random segments checked by the model every cycle
    for (int seg = 0; seg < 4; seg++) begin
      for (int i = 0; i < NS; i++) begin
        cfg_src[i*4 +: 4]   = 4'($urandom % 16);
        cfg_dly[i*DW +: DW] = DW'($urandom % 6);
        cfg_div[i*2 +: 2]   = 2'($urandom % 4);
        cfg_ext_rise[i]     = 1'($urandom % 2);
        cfg_ext_fall[i]     = 1'($urandom % 2);
      end
      for (int k = 0; k < 600; k++) begin
        eoc_pulse = 2'($urandom & $urandom & $urandom);
        tmr_ovf   = 4'($urandom & $urandom & $urandom);
        pwm_evt   = 8'($urandom & $urandom & $urandom);
        sw_start  = NS'($urandom & $urandom & $urandom & $urandom);
        ovr_clr   = NS'($urandom & $urandom & $urandom & $urandom);
        grant     = 1'($urandom % 2);
        if ($urandom % 4 == 0) ext_pin = ~ext_pin;
        cycle();
      end
      for (int k = 0; k < 120; k++) begin
        grant = 1'b1;
        ovr_clr = '1;
        cycle();
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule